// File: doc/BRIEF.md
# Power-Controller Command Transaction Engine

This block sits on the host side of a byte-wide shift link to a power-management microcontroller and runs one command transaction at a time. A transaction starts with an opcode. A per-opcode length lookup decides how many bytes go out and how many come back. Either direction can be a fixed count, or a variable count that is carried in a length byte on the link. The engine sends the opcode, an optional length byte and the payload. It then shifts in the reply and stores it in a reply buffer, and pulses a done strobe together with the byte count.

Each byte uses a request/acknowledge handshake. The host loads the shifter and pulls the active-low request line low. When the shift completes, the host releases the request line. The next byte waits until the controller raises its active-low acknowledge line again. If acknowledge stays low too long, the transaction is dropped and a timeout error is flagged.

The controller can also signal pending interrupts. Whenever the engine is idle, a pending interrupt is served before any queued command: the engine sends the acknowledge opcode and reads back a variable-length interrupt packet. A single request slot holds the next command. A request marked as expecting a deferred reply is held back while an earlier deferred request still waits for its reply. That reply is taken to have arrived when an interrupt packet completes.

Top module: `pmx_cmd_engine`

## Requirements
- R1: Length rule per opcode `op`. The send count is variable when `op[3]`=1, otherwise it is `op[2:0]`. The receive count is variable when `op[4]`=1, otherwise it is `{op[7],op[6:5]}`.
- R2: Outgoing bytes appear in this order: the opcode, then the payload byte count (only if the send count is variable), then payload bytes 0..n-1 taken from `req_data_i[8*i+:8]`.
- R3: Each byte is handshaken. `sh_load_o` pulses while `treq_no` goes low. `treq_no` returns high only after `sh_done_i`. The next byte is loaded only after `tack_ni` has been seen high.
- R4: If `tack_ni` stays low for TIMEOUT_CYC cycles after `treq_no` is released, `err_timeout_o` pulses, the transaction is dropped without `rsp_done_o`, and the engine accepts and runs later requests normally.
- R5: After the last sent byte, a receive count of 0 gives `rsp_done_o` with `rsp_cnt_o`=0. A fixed receive count N reads N bytes into `rsp_data_o[8*i+:8]` and reports `rsp_cnt_o`=N.
- R6: With a variable receive count, the first byte read is the length L. L above MAX_PAY (32) pulses `err_badlen_o` without `rsp_done_o`. L up to 32 reads L bytes. Only one of done, timeout or bad-length pulses in any cycle.
- R7: With an interrupt pending at an idle point, the engine sends ACK_OP (default 8'h10) before any queued request, clears the pending flag, reads a variable-length packet, and finishes with `rsp_done_o` and `rsp_intr_o`=1.
- R8: A request is rejected with a `req_reject_o` pulse, is never sent, and leaves `req_ready_o` high in either of two cases: its opcode has a fixed send count different from `req_cnt_i`, or `req_cnt_i` exceeds 32.
- R9: A deferred request (`req_defer_i`=1) whose transaction ends with receive count 0 leaves a reply outstanding. A later deferred request is not started until an interrupt packet completes. Non-deferred requests run meanwhile.
- R10: After reset `treq_no`=1, `req_ready_o`=1, and `sh_load_o`, `rsp_done_o`, `err_timeout_o`, `err_badlen_o` and `req_reject_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Controller interrupt event; sets the pending flag |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request slot empty |
| req_op_i | input | 8 | Request opcode |
| req_cnt_i | input | 6 | Payload byte count |
| req_data_i | input | 256 | Payload, byte i at bits 8i+7:8i |
| req_defer_i | input | 1 | Request expects a deferred reply |
| req_reject_o | output | 1 | Pulse: offered request refused |
| sh_load_o | output | 1 | Pulse: load the shifter |
| sh_dir_o | output | 1 | 1 = shift out, 0 = shift in |
| sh_tx_o | output | 8 | Byte to shift out |
| sh_rx_i | input | 8 | Byte shifted in, valid with sh_done_i |
| sh_done_i | input | 1 | Pulse: shift complete |
| treq_no | output | 1 | Active-low transfer request |
| tack_ni | input | 1 | Active-low transfer acknowledge |
| rsp_done_o | output | 1 | Pulse: transaction complete |
| rsp_intr_o | output | 1 | Completed transaction was an interrupt packet |
| rsp_cnt_o | output | 6 | Reply bytes received |
| rsp_data_o | output | 256 | Reply buffer, byte i at bits 8i+7:8i |
| err_timeout_o | output | 1 | Pulse: acknowledge never returned |
| err_badlen_o | output | 1 | Pulse: reply length byte above 32 |

## Verification
The assertions assume that the link partner raises `sh_done_i` only while the engine is shifting and keeps `tack_ni` low from a load until after the shift completes. The bench's link model enforces this: it reacts only to an observed `sh_load_o`, pulls `tack_ni` low at once, and raises it again after the shift pulse. They also assume that `irq_i` and requests may arrive in any cycle. The bench covers this by pulsing the interrupt in the same cycle a request is offered, and while a deferred request is waiting. Random opcodes are paired with payload counts that the length rule accepts, so that rejections only come from the directed cases.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  typedef struct packed {
    logic [7:0] snd;  // 8'hFF = variable (length byte on link)
    logic [7:0] rcv;
  } len_pair_t;

  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_LEN, S_PAY, S_RLEN, S_RDAT
  } eng_st_t;

  typedef enum logic [1:0] {
    H_IDLE, H_SHIFT, H_WAIT
  } hs_st_t;

  function automatic len_pair_t len_rule(input logic [7:0] op);
    len_pair_t p;
    p.snd = op[3] ? 8'hFF : {5'b0, op[2:0]};
    p.rcv = op[4] ? 8'hFF : {5'b0, op[7], op[6:5]};
    return p;
  endfunction

endpackage

// File: rtl/pmx_len_table.sv
module pmx_len_table
  import pmx_pkg::*;
(
  input  logic [7:0] op_i,
  output len_pair_t  len_o
);
  localparam int N_OP = 256;

  len_pair_t tab [N_OP];

  for (genvar g = 0; g < N_OP; g++) begin : g_ent
    assign tab[g] = len_rule(8'(g));
  end

  assign len_o = tab[op_i];

endmodule

// File: rtl/pmx_byte_hs.sv
module pmx_byte_hs
  import pmx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3200,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       dir_out_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic       tout_o,
  output logic [7:0] rx_o,
  output logic       sh_load_o,
  output logic       sh_dir_o,
  output logic [7:0] sh_tx_o,
  input  logic [7:0] sh_rx_i,
  input  logic       sh_done_i,
  output logic       treq_no,
  input  logic       tack_ni
);
  hs_st_t        st_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= H_IDLE;
      treq_no   <= 1'b1;
      sh_load_o <= 1'b0;
      sh_dir_o  <= 1'b0;
      sh_tx_o   <= '0;
      rx_o      <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      tout_o    <= 1'b0;
    end else begin
      sh_load_o <= 1'b0;
      done_o    <= 1'b0;
      tout_o    <= 1'b0;
      unique case (st_q)
        H_IDLE: if (start_i) begin
          sh_load_o <= 1'b1;
          treq_no   <= 1'b0;
          sh_dir_o  <= dir_out_i;
          sh_tx_o   <= tx_i;
          st_q      <= H_SHIFT;
        end
        H_SHIFT: if (sh_done_i) begin
          treq_no <= 1'b1;
          rx_o    <= sh_rx_i;
          cnt_q   <= '0;
          st_q    <= H_WAIT;
        end
        H_WAIT: begin
          if (tack_ni) begin
            done_o <= 1'b1;
            st_q   <= H_IDLE;
          end else if (cnt_q == TW'(TIMEOUT_CYC - 1)) begin
            tout_o <= 1'b1;
            st_q   <= H_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= H_IDLE;
      endcase
    end
  end

  assert_start_on_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == H_IDLE && start_i) |-> tack_ni);

  assert_release_after_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(treq_no) |-> $past(sh_done_i));

  assert_tout_on_low_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |-> $past(!tack_ni));

endmodule

// File: rtl/pmx_rsp_buf.sv
module pmx_rsp_buf #(
  parameter int MAX_PAY = 32,
  localparam int CW = $clog2(MAX_PAY + 1),
  localparam int DW = MAX_PAY * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [CW-1:0] idx_i,
  input  logic [7:0]    d_i,
  output logic [DW-1:0] q_o
);
  logic [7:0] mem [MAX_PAY];

  for (genvar g = 0; g < MAX_PAY; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem[g] <= '0;
      else if (clr_i)                        mem[g] <= '0;
      else if (wr_i && idx_i == CW'(g))      mem[g] <= d_i;
    end
    assign q_o[g*8 +: 8] = mem[g];
  end

endmodule

// File: rtl/pmx_cmd_engine.sv
module pmx_cmd_engine
  import pmx_pkg::*;
#(
  parameter int         MAX_PAY     = 32,
  parameter int         TIMEOUT_CYC = 3200,
  parameter logic [7:0] ACK_OP      = 8'h10,
  localparam int CW = $clog2(MAX_PAY + 1),
  localparam int DW = MAX_PAY * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [7:0]    req_op_i,
  input  logic [CW-1:0] req_cnt_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          req_defer_i,
  output logic          req_reject_o,
  output logic          sh_load_o,
  output logic          sh_dir_o,
  output logic [7:0]    sh_tx_o,
  input  logic [7:0]    sh_rx_i,
  input  logic          sh_done_i,
  output logic          treq_no,
  input  logic          tack_ni,
  output logic          rsp_done_o,
  output logic          rsp_intr_o,
  output logic [CW-1:0] rsp_cnt_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          err_timeout_o,
  output logic          err_badlen_o
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_PAY);
  localparam logic [7:0]    MAX_B = 8'(MAX_PAY);

  len_pair_t req_len;

  // request slot
  logic          slot_v_q, slot_def_q;
  logic [7:0]    slot_op_q;
  logic [CW-1:0] slot_cnt_q;
  logic [DW-1:0] slot_data_q;
  len_pair_t     slot_len_q;

  // active transaction
  eng_st_t       st_q, st_n;
  logic          go_q, go_n;
  logic [7:0]    cur_op_q;
  logic [CW-1:0] cur_cnt_q;
  logic [DW-1:0] cur_data_q;
  logic          cur_def_q, cur_intr_q;
  len_pair_t     cur_len_q;
  logic [CW-1:0] idx_q, idx_n, rlen_q, rlen_n;
  logic          pend_q, await_q;

  logic          take_irq, take_req, tx_end, fin, bad_len, wr_en;
  logic          hs_done, hs_tout;
  logic [7:0]    hs_rx, tx_byte;
  logic          req_bad;

  pmx_len_table u_tab (.op_i(req_op_i), .len_o(req_len));

  assign req_bad = (req_cnt_i > MAX_C) ||
                   (!req_len.snd[7] && req_len.snd != 8'(req_cnt_i));

  assign req_ready_o = !slot_v_q;

  always_comb begin
    st_n     = st_q;
    go_n     = 1'b0;
    idx_n    = idx_q;
    rlen_n   = rlen_q;
    take_irq = 1'b0;
    take_req = 1'b0;
    tx_end   = 1'b0;
    fin      = 1'b0;
    bad_len  = 1'b0;
    wr_en    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (pend_q) begin
          take_irq = 1'b1;
          st_n = S_OP;
          go_n = 1'b1;
        end else if (slot_v_q && !(slot_def_q && await_q)) begin
          take_req = 1'b1;
          st_n = S_OP;
          go_n = 1'b1;
        end
      end
      S_OP: if (hs_done) begin
        if (cur_len_q.snd[7]) begin
          st_n = S_LEN;
          go_n = 1'b1;
        end else if (cur_len_q.snd != 8'd0) begin
          st_n  = S_PAY;
          idx_n = '0;
          go_n  = 1'b1;
        end else begin
          tx_end = 1'b1;
        end
      end
      S_LEN: if (hs_done) begin
        if (cur_cnt_q != '0) begin
          st_n  = S_PAY;
          idx_n = '0;
          go_n  = 1'b1;
        end else begin
          tx_end = 1'b1;
        end
      end
      S_PAY: if (hs_done) begin
        if (idx_q == cur_cnt_q - 1'b1) begin
          tx_end = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
          go_n  = 1'b1;
        end
      end
      S_RLEN: if (hs_done) begin
        if (hs_rx > MAX_B) begin
          bad_len = 1'b1;
          st_n    = S_IDLE;
        end else if (hs_rx == 8'd0) begin
          fin  = 1'b1;
          st_n = S_IDLE;
        end else begin
          rlen_n = hs_rx[CW-1:0];
          idx_n  = '0;
          st_n   = S_RDAT;
          go_n   = 1'b1;
        end
      end
      S_RDAT: if (hs_done) begin
        wr_en = 1'b1;
        if (idx_q == rlen_q - 1'b1) begin
          fin  = 1'b1;
          st_n = S_IDLE;
        end else begin
          idx_n = idx_q + 1'b1;
          go_n  = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (tx_end) begin
      if (cur_len_q.rcv == 8'd0) begin
        fin  = 1'b1;
        st_n = S_IDLE;
      end else if (cur_len_q.rcv[7]) begin
        st_n = S_RLEN;
        go_n = 1'b1;
      end else begin
        st_n   = S_RDAT;
        idx_n  = '0;
        rlen_n = cur_len_q.rcv[CW-1:0];
        go_n   = 1'b1;
      end
    end

    if (hs_tout) begin
      st_n = S_IDLE;
      go_n = 1'b0;
    end
  end

  always_comb begin
    unique case (st_q)
      S_OP:    tx_byte = cur_op_q;
      S_LEN:   tx_byte = 8'(cur_cnt_q);
      S_PAY:   tx_byte = cur_data_q[{idx_q, 3'b000} +: 8];
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= S_IDLE;
      go_q          <= 1'b0;
      idx_q         <= '0;
      rlen_q        <= '0;
      slot_v_q      <= 1'b0;
      slot_def_q    <= 1'b0;
      slot_op_q     <= '0;
      slot_cnt_q    <= '0;
      slot_data_q   <= '0;
      slot_len_q    <= '0;
      cur_op_q      <= '0;
      cur_cnt_q     <= '0;
      cur_data_q    <= '0;
      cur_def_q     <= 1'b0;
      cur_intr_q    <= 1'b0;
      cur_len_q     <= '0;
      pend_q        <= 1'b0;
      await_q       <= 1'b0;
      req_reject_o  <= 1'b0;
      rsp_done_o    <= 1'b0;
      rsp_intr_o    <= 1'b0;
      rsp_cnt_o     <= '0;
      err_timeout_o <= 1'b0;
      err_badlen_o  <= 1'b0;
    end else begin
      st_q   <= st_n;
      go_q   <= go_n;
      idx_q  <= idx_n;
      rlen_q <= rlen_n;

      req_reject_o <= 1'b0;
      if (req_valid_i && !slot_v_q) begin
        if (req_bad) begin
          req_reject_o <= 1'b1;
        end else begin
          slot_v_q    <= 1'b1;
          slot_op_q   <= req_op_i;
          slot_cnt_q  <= req_cnt_i;
          slot_data_q <= req_data_i;
          slot_def_q  <= req_defer_i;
          slot_len_q  <= req_len;
        end
      end

      if (take_irq) begin
        cur_op_q   <= ACK_OP;
        cur_cnt_q  <= '0;
        cur_data_q <= '0;
        cur_def_q  <= 1'b0;
        cur_intr_q <= 1'b1;
        cur_len_q  <= '{snd: 8'h00, rcv: 8'hFF};
      end else if (take_req) begin
        cur_op_q   <= slot_op_q;
        cur_cnt_q  <= slot_cnt_q;
        cur_data_q <= slot_data_q;
        cur_def_q  <= slot_def_q;
        cur_intr_q <= 1'b0;
        cur_len_q  <= slot_len_q;
        slot_v_q   <= 1'b0;
      end

      if (irq_i)         pend_q <= 1'b1;
      else if (take_irq) pend_q <= 1'b0;

      if (fin && cur_intr_q)                    await_q <= 1'b0;
      else if (fin && tx_end && cur_def_q)      await_q <= 1'b1;

      rsp_done_o    <= fin;
      rsp_intr_o    <= fin && cur_intr_q;
      if (fin) rsp_cnt_o <= (st_q == S_RDAT) ? idx_q + 1'b1 : '0;
      err_timeout_o <= hs_tout;
      err_badlen_o  <= bad_len;
    end
  end

  pmx_byte_hs #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (go_q),
    .dir_out_i (st_q == S_OP || st_q == S_LEN || st_q == S_PAY),
    .tx_i      (tx_byte),
    .done_o    (hs_done),
    .tout_o    (hs_tout),
    .rx_o      (hs_rx),
    .sh_load_o (sh_load_o),
    .sh_dir_o  (sh_dir_o),
    .sh_tx_o   (sh_tx_o),
    .sh_rx_i   (sh_rx_i),
    .sh_done_i (sh_done_i),
    .treq_no   (treq_no),
    .tack_ni   (tack_ni)
  );

  pmx_rsp_buf #(.MAX_PAY(MAX_PAY)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take_irq || take_req),
    .wr_i   (wr_en),
    .idx_i  (idx_q),
    .d_i    (hs_rx),
    .q_o    (rsp_data_o)
  );

  assert_irq_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && pend_q) |=> (st_q == S_OP && cur_intr_q && cur_op_q == ACK_OP));

  assert_defer_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !pend_q && slot_v_q && slot_def_q && await_q) |=> (st_q == S_IDLE));

  assert_one_outcome_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_done_o, err_timeout_o, err_badlen_o}));

  assert_reject_not_stored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_reject_o |-> $stable(slot_v_q));

endmodule

// File: tb/pmx_cmd_engine_tb.sv
module pmx_cmd_engine_tb;
  localparam int MAX_PAY = 32;
  localparam int CW = $clog2(MAX_PAY + 1);
  localparam int DW = MAX_PAY * 8;
  localparam logic [7:0] ACK = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_op = '0;
  logic [CW-1:0] req_cnt = '0;
  logic [DW-1:0] req_data = '0;
  logic req_defer = 1'b0;
  logic req_reject;
  logic sh_load, sh_dir;
  logic [7:0] sh_tx;
  logic [7:0] sh_rx = '0;
  logic sh_done = 1'b0;
  logic treq_n;
  logic tack_n = 1'b1;
  logic rsp_done, rsp_intr;
  logic [CW-1:0] rsp_cnt;
  logic [DW-1:0] rsp_data;
  logic err_to, err_bl;

  int checks = 0;
  int errors = 0;

  logic [7:0] txlog [0:127];
  int txn = 0;
  logic [7:0] rxq [0:127];
  int rxw = 0;
  int rxr = 0;
  bit stuck = 1'b0;
  bit m_busy = 1'b0;
  int m_ph = 0;
  int m_cnt = 0;
  bit m_dir = 1'b0;
  int ovl = 0;
  logic [7:0] pay [0:31];

  always #5 clk = ~clk;

  pmx_cmd_engine #(.MAX_PAY(MAX_PAY), .TIMEOUT_CYC(64), .ACK_OP(ACK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_cnt_i(req_cnt), .req_data_i(req_data), .req_defer_i(req_defer),
    .req_reject_o(req_reject),
    .sh_load_o(sh_load), .sh_dir_o(sh_dir), .sh_tx_o(sh_tx), .sh_rx_i(sh_rx),
    .sh_done_i(sh_done), .treq_no(treq_n), .tack_ni(tack_n),
    .rsp_done_o(rsp_done), .rsp_intr_o(rsp_intr), .rsp_cnt_o(rsp_cnt),
    .rsp_data_o(rsp_data), .err_timeout_o(err_to), .err_badlen_o(err_bl)
  );

  // R1 length rule, written from the requirement
  function automatic int exp_snd(input logic [7:0] op);
    return op[3] ? -1 : int'(op[2:0]);
  endfunction
  function automatic int exp_rcv(input logic [7:0] op);
    return op[4] ? -1 : int'({op[7], op[6:5]});
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // link partner model, acts on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (!m_busy) begin
        sh_done = 1'b0;
        if (sh_load) begin
          m_busy = 1'b1; m_ph = 0; m_cnt = 0; tack_n = 1'b0; m_dir = sh_dir;
          if (sh_dir) begin txlog[txn] = sh_tx; txn++; end
        end
      end else begin
        if (sh_load) ovl++;
        if (m_ph == 0) begin
          m_cnt++;
          if (m_cnt == 2) begin
            sh_done = 1'b1;
            if (m_dir) sh_rx = 8'h00;
            else begin sh_rx = rxq[rxr]; rxr++; end
            m_ph = 1; m_cnt = 0;
          end
        end else begin
          sh_done = 1'b0;
          m_cnt++;
          if (m_cnt >= 2 && !stuck) begin
            if (!treq_n) ovl++;
            tack_n = 1'b1; m_busy = 1'b0;
          end
        end
      end
    end
  end

  task automatic push_rx(input logic [7:0] b);
    rxq[rxw] = b; rxw++;
  endtask

  task automatic clr_link();
    txn = 0; rxr = 0; rxw = 0;
  endtask

  task automatic drive_req(input logic [7:0] op, input int n, input bit dfr);
    req_op = op; req_cnt = CW'(n); req_defer = dfr; req_data = '0;
    for (int i = 0; i < 32; i++) if (i < n) req_data[i*8 +: 8] = pay[i];
    req_valid = 1'b1;
  endtask

  task automatic send_req(input logic [7:0] op, input int n, input bit dfr, output bit rej);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    drive_req(op, n, dfr);
    @(negedge clk);
    rej = req_reject;
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit t, output bit b, output bit it);
    d = 0; t = 0; b = 0; it = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (rsp_done || err_to || err_bl) begin
        d = rsp_done; t = err_to; b = err_bl; it = rsp_intr;
        break;
      end
    end
  endtask

  task automatic do_txn(input logic [7:0] op, input int n, input int vlen);
    int es, er, ntx, nrx, mism;
    logic [7:0] etx [0:40];
    logic [7:0] erx [0:40];
    bit rej, d, t, b, it;
    es = exp_snd(op); er = exp_rcv(op);
    clr_link();
    etx[0] = op; ntx = 1;
    if (es < 0) begin etx[ntx] = 8'(n); ntx++; end
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'($urandom); etx[ntx] = pay[i]; ntx++;
    end
    if (er < 0) begin push_rx(8'(vlen)); nrx = vlen; end
    else nrx = er;
    for (int i = 0; i < nrx; i++) begin erx[i] = 8'($urandom); push_rx(erx[i]); end
    send_req(op, n, 1'b0, rej);
    wait_end(d, t, b, it);
    chk(d && !rej && !it, (er < 0) ? "R6 variable reply done" : "R5 fixed reply done",
        int'({rej, d, t, b}), 4'b0100);
    chk(rsp_cnt == CW'(nrx), (er < 0) ? "R6 reply count" : "R5 reply count", rsp_cnt, nrx);
    mism = 0;
    for (int i = 0; i < nrx; i++) if (rsp_data[i*8 +: 8] !== erx[i]) mism++;
    chk(mism == 0, "R5 reply bytes", mism, 0);
    mism = (ntx == txn) ? 0 : 100;
    for (int i = 0; i < ntx; i++) if (i < txn && txlog[i] !== etx[i]) mism++;
    chk(mism == 0, (es < 0) ? "R2 tx order with length byte" : "R2 tx order fixed",
        txn, ntx);
  endtask

  initial begin
    bit rej, d, t, b, it;
    int seen;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(treq_n === 1'b1 && req_ready === 1'b1 && !sh_load && !rsp_done && !err_to && !err_bl
        && !req_reject, "R10 reset outputs", {treq_n, req_ready}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(treq_n === 1'b1 && req_ready === 1'b1, "R10 after reset release", treq_n, 1);

    // directed: fixed, variable, zero-length replies
    do_txn(8'h00, 0, 0);             // R5 send 0 recv 0
    do_txn(8'h23, 3, 0);             // R1 snd 3, rcv 1
    do_txn(8'hE7, 7, 0);             // R1 snd 7, rcv 7
    do_txn(8'h08, 5, 0);             // R2 variable send
    do_txn(8'h08, 0, 0);             // R2 variable send, empty payload
    do_txn(8'h18, 32, 4);            // R2/R6 max payload, variable both
    do_txn(8'h90, 0, 0);             // R6 variable length 0
    do_txn(8'h90, 0, 32);            // R6 boundary length 32

    // R6 bad length
    clr_link(); push_rx(8'd33);
    send_req(8'h90, 0, 1'b0, rej);
    wait_end(d, t, b, it);
    chk(b && !d && !t, "R6 bad length flagged", int'({d, t, b}), 3'b001);

    // R8 rejections
    clr_link(); pay[0] = 8'h11;
    send_req(8'h02, 1, 1'b0, rej);
    chk(rej, "R8 fixed count mismatch rejected", rej, 1);
    repeat (20) @(negedge clk);
    chk(txn == 0 && req_ready && !rsp_done, "R8 rejected not sent", txn, 0);
    send_req(8'h08, 33, 1'b0, rej);
    chk(rej, "R8 oversize payload rejected", rej, 1);
    repeat (20) @(negedge clk);
    chk(txn == 0 && req_ready, "R8 oversize not sent", txn, 0);

    // R7 interrupt priority over a request offered in the same cycle
    clr_link();
    push_rx(8'd2); push_rx(8'hA1); push_rx(8'hB2);
    pay[0] = 8'h33;
    @(negedge clk);
    irq = 1'b1; drive_req(8'h01, 1, 1'b0);
    @(negedge clk);
    irq = 1'b0; req_valid = 1'b0;
    wait_end(d, t, b, it);
    chk(d && it && rsp_cnt == 2 && rsp_data[7:0] == 8'hA1 && rsp_data[15:8] == 8'hB2,
        "R7 interrupt packet first", rsp_cnt, 2);
    chk(txlog[0] == ACK, "R7 ack opcode sent", txlog[0], ACK);
    wait_end(d, t, b, it);
    chk(d && !it && txn == 3 && txlog[1] == 8'h01 && txlog[2] == 8'h33,
        "R7 queued request after interrupt", txn, 3);

    // R9 deferred reply hold
    clr_link();
    send_req(8'h00, 0, 1'b1, rej);
    wait_end(d, t, b, it);
    chk(d && rsp_cnt == 0, "R9 first deferred completes", d, 1);
    do_txn(8'h01, 1, 0);             // R9 non-deferred runs while reply outstanding
    clr_link();
    send_req(8'h00, 0, 1'b1, rej);
    seen = 0;
    repeat (40) begin @(negedge clk); if (rsp_done || sh_load) seen++; end
    chk(txn == 0 && seen == 0, "R9 second deferred held", txn, 0);
    push_rx(8'd1); push_rx(8'h5A);
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
    wait_end(d, t, b, it);
    chk(d && it && rsp_data[7:0] == 8'h5A, "R9 interrupt packet releases", rsp_data[7:0], 8'h5A);
    wait_end(d, t, b, it);
    chk(d && !it && txn == 2 && txlog[1] == 8'h00, "R9 deferred runs after release", txn, 2);

    // R4 timeout and recovery
    clr_link(); stuck = 1'b1; pay[0] = 8'h44;
    send_req(8'h01, 1, 1'b0, rej);
    wait_end(d, t, b, it);
    chk(t && !d, "R4 timeout flagged", int'({d, t}), 2'b01);
    stuck = 1'b0;
    while (m_busy) @(negedge clk);
    do_txn(8'h21, 1, 0);             // R4 recovery

    // random mix
    for (int r = 0; r < 24; r++) begin
      logic [7:0] op;
      int n;
      op = 8'($urandom);
      n = (exp_snd(op) < 0) ? int'($urandom_range(0, 6)) : exp_snd(op);
      do_txn(op, n, int'($urandom_range(0, 6)));
    end

    chk(ovl == 0, "R3 handshake order", ovl, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung act=%0d exp=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule